// File: doc/BRIEF.md
# CAN Error Counter Unit

This block holds the transmit and receive error counts of one CAN node and derives the node's two-bit fault confinement state from them. A protocol engine drives it with single-cycle event pulses. A transmit error raises the transmit count by 8 and a good transmission lowers it by 1. A receive error raises the receive count by 1 and a good reception lowers it by 1. A separate pulse marks the end of a bus-off recovery.

Both counts are presented together on one read-only 16-bit word. When a count runs past its 8-bit range, its visible value drops into the 0 to 7 band. From then on that count holds still, and a sticky state records the event: bus off for the transmit side, error passive for the receive side. Only the recovery pulse returns the node to error active.

Top module: `can_err_count`

## Requirements
- R1: After reset both counts are zero and the node state is 2'b00. The transmit count is on err_word_o[15:8] and the receive count is on err_word_o[7:0].
- R2: A transmit error pulse adds 8 to the transmit count. A transmit success pulse subtracts 1. A success pulse at zero leaves the count at zero.
- R3: A receive error pulse adds 1 to the receive count. A receive success pulse subtracts 1. A success pulse at zero leaves the count at zero.
- R4: When the error and success pulses of one counter arrive in the same cycle, only the error is applied.
- R5: When a transmit error pushes the 9-bit sum to 256 or more, the transmit count shows the low 8 bits of that sum (0 to 7). After that, transmit pulses leave it unchanged.
- R6: A transmit overflow sets the node state to 2'b11 (bus off). The state stays there, whatever the counts, until recovery.
- R7: When a receive error pushes the sum to 256, the receive count shows its low 8 bits. After that, receive pulses leave it unchanged.
- R8: A receive overflow sets the node state to 2'b10 (error passive) and holds it there, unless bus off is in effect.
- R9: With no overflow, the node state is 2'b00 while both counts are below 96. It is 2'b01 when the larger count is 96 to 127, and 2'b10 when either count is 128 or more.
- R10: A recovery pulse clears both counts, both overflow conditions and the node state to 2'b00. It takes priority over any event pulse in the same cycle.
- R11: Outputs reflect an event pulse from the first clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error event |
| tx_ok_i | input | 1 | Transmit success event |
| rx_err_i | input | 1 | Receive error event |
| rx_ok_i | input | 1 | Receive success event |
| bus_recover_i | input | 1 | Bus-off recovery complete |
| err_word_o | output | 16 | {transmit count, receive count} |
| node_state_o | output | 2 | 00 active, 01 warning, 10 passive, 11 bus off |

## Verification
The hardest case to reach is a transmit overflow whose wrapped value is not zero. With steps of +8 and −1, the count must first be moved off a multiple of 8 by success pulses and then pushed past 255. The bench reaches 242 through 31 errors and 6 successes, then applies two more errors, which gives a sum of 258 and a visible value of 2. It also builds a receive overflow first, so that it can confirm bus off overrides the sticky error-passive state.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_WARN    = 2'b01,
    ST_PASSIVE = 2'b10,
    ST_BUSOFF  = 2'b11
  } node_state_e;
endpackage

// File: rtl/err_counter.sv
module err_counter #(
  parameter int W   = 8,
  parameter int INC = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  localparam int SW = W + 1;

  logic [W-1:0]  cnt_q;
  logic          ovf_q;
  logic [SW-1:0] sum;

  assign sum = {1'b0, cnt_q} + SW'(INC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (!ovf_q) begin
      // error wins over success
      if (inc_i) begin
        cnt_q <= sum[W-1:0];
        ovf_q <= sum[W];
      end else if (dec_i && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/node_state_unit.sv
module node_state_unit
  import can_err_pkg::*;
#(
  parameter int W           = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128
) (
  input  logic [W-1:0] tx_cnt_i,
  input  logic [W-1:0] rx_cnt_i,
  input  logic         tx_ovf_i,
  input  logic         rx_ovf_i,
  output node_state_e  state_o
);
  localparam logic [W-1:0] WARN_C = W'(WARN_LVL);
  localparam logic [W-1:0] PASS_C = W'(PASSIVE_LVL);

  always_comb begin
    if (tx_ovf_i)
      state_o = ST_BUSOFF;
    else if (rx_ovf_i || tx_cnt_i >= PASS_C || rx_cnt_i >= PASS_C)
      state_o = ST_PASSIVE;
    else if (tx_cnt_i >= WARN_C || rx_cnt_i >= WARN_C)
      state_o = ST_WARN;
    else
      state_o = ST_ACTIVE;
  end
endmodule

// File: rtl/can_err_count.sv
module can_err_count
  import can_err_pkg::*;
#(
  parameter int W           = 8,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_err_i,
  input  logic         tx_ok_i,
  input  logic         rx_err_i,
  input  logic         rx_ok_i,
  input  logic         bus_recover_i,
  output logic [2*W-1:0] err_word_o,
  output logic [1:0]   node_state_o
);
  logic [W-1:0] tx_cnt, rx_cnt;
  logic         tx_ovf, rx_ovf;
  node_state_e  state;

  err_counter #(.W(W), .INC(TX_STEP)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(bus_recover_i),
    .inc_i(tx_err_i), .dec_i(tx_ok_i),
    .cnt_o(tx_cnt), .ovf_o(tx_ovf)
  );

  err_counter #(.W(W), .INC(RX_STEP)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(bus_recover_i),
    .inc_i(rx_err_i), .dec_i(rx_ok_i),
    .cnt_o(rx_cnt), .ovf_o(rx_ovf)
  );

  node_state_unit #(.W(W), .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)) u_st (
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .tx_ovf_i(tx_ovf), .rx_ovf_i(rx_ovf),
    .state_o(state)
  );

  assign err_word_o   = {tx_cnt, rx_cnt};
  assign node_state_o = state;
endmodule

// File: rtl/can_err_chk.sv
module can_err_chk #(
  parameter int W       = 8,
  parameter int TX_STEP = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tx_err_i,
  input logic           tx_ok_i,
  input logic           rx_err_i,
  input logic           rx_ok_i,
  input logic           bus_recover_i,
  input logic [2*W-1:0] err_word_o,
  input logic [1:0]     node_state_o,
  input logic           tx_ovf_i,
  input logic           rx_ovf_i
);
  localparam logic [W-1:0] TX_LIM = W'((1 << W) - TX_STEP);

  a_r2_tx_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_ovf_i && tx_err_i && !bus_recover_i && err_word_o[2*W-1:W] < TX_LIM)
    |=> err_word_o[2*W-1:W] == $past(err_word_o[2*W-1:W]) + W'(TX_STEP));

  a_r3_rx_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_word_o[W-1:0] == '0 && !rx_err_i && !bus_recover_i) |=> err_word_o[W-1:0] == '0);

  a_r5_tx_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_i && !bus_recover_i) |=> $stable(err_word_o[2*W-1:W]));

  a_r6_busoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ovf_i |-> node_state_o == 2'b11);

  a_r7_rx_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_i && !bus_recover_i) |=> $stable(err_word_o[W-1:0]));

  a_r8_passive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_i && !tx_ovf_i) |-> node_state_o == 2'b10);

  a_r10_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_recover_i |=> (err_word_o == '0 && node_state_o == 2'b00));
endmodule

bind can_err_count can_err_chk #(.W(W), .TX_STEP(TX_STEP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i),
  .rx_err_i(rx_err_i), .rx_ok_i(rx_ok_i),
  .bus_recover_i(bus_recover_i),
  .err_word_o(err_word_o), .node_state_o(node_state_o),
  .tx_ovf_i(tx_ovf), .rx_ovf_i(rx_ovf)
);

// File: tb/sim_can_err_count.sv
`timescale 1ns/1ps
module sim_can_err_count;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_err = 0, tx_ok = 0, rx_err = 0, rx_ok = 0, rec = 0;
  logic [15:0] word;
  logic [1:0]  st;

  int n_chk = 0, n_fail = 0;
  int m_tx = 0, m_rx = 0;
  bit m_txo = 0, m_rxo = 0;

  always #2 clk = ~clk;

  can_err_count u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_err_i(tx_err), .tx_ok_i(tx_ok), .rx_err_i(rx_err), .rx_ok_i(rx_ok),
    .bus_recover_i(rec), .err_word_o(word), .node_state_o(st)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_state();
    if (m_txo) return 3;
    if (m_rxo || m_tx >= 128 || m_rx >= 128) return 2;
    if (m_tx >= 96 || m_rx >= 96) return 1;
    return 0;
  endfunction

  // one event cycle; model update follows the requirements
  task automatic step(bit te, bit to, bit re, bit ro, bit rc);
    tx_err = te; tx_ok = to; rx_err = re; rx_ok = ro; rec = rc;
    @(negedge clk);
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; rec = 0;
    if (rc) begin
      m_tx = 0; m_rx = 0; m_txo = 0; m_rxo = 0;
    end else begin
      if (!m_txo) begin
        if (te) begin m_tx += 8; if (m_tx > 255) begin m_txo = 1; m_tx -= 256; end end
        else if (to && m_tx > 0) m_tx -= 1;
      end
      if (!m_rxo) begin
        if (re) begin m_rx += 1; if (m_rx > 255) begin m_rxo = 1; m_rx -= 256; end end
        else if (ro && m_rx > 0) m_rx -= 1;
      end
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " tx"}, int'(word[15:8]), m_tx);
    chk({req, " rx"}, int'(word[7:0]), m_rx);
    chk({req, " state"}, int'(st), exp_state());
  endtask

  task automatic t_reset();
    chk("R1 word", int'(word), 0);
    chk("R1 state", int'(st), 0);
  endtask

  task automatic t_tx_basic();
    step(1,0,0,0,0);
    chk("R11 tx after one edge", int'(word[15:8]), 8);
    step(1,0,0,0,0); step(1,0,0,0,0);
    step(0,1,0,0,0); step(0,1,0,0,0);
    chk("R2 tx 22", int'(word[15:8]), 22);
    chk_all("R2");
    for (int i = 0; i < 25; i++) step(0,1,0,0,0);
    chk("R2 tx floor", int'(word[15:8]), 0);
  endtask

  task automatic t_rx_basic();
    step(0,0,0,1,0);
    chk("R3 rx floor", int'(word[7:0]), 0);
    for (int i = 0; i < 5; i++) step(0,0,1,0,0);
    step(0,0,0,1,0);
    chk("R3 rx 4", int'(word[7:0]), 4);
    chk_all("R3");
  endtask

  task automatic t_priority();
    step(1,1,1,1,0);
    chk("R4 tx", int'(word[15:8]), 8);
    chk("R4 rx", int'(word[7:0]), 5);
    step(0,0,0,0,1);
  endtask

  task automatic t_levels();
    for (int i = 0; i < 95; i++) step(0,0,1,0,0);
    chk("R9 95 active", int'(st), 0);
    step(0,0,1,0,0);
    chk("R9 96 warn", int'(st), 1);
    for (int i = 0; i < 32; i++) step(0,0,1,0,0);
    chk("R9 128 passive", int'(st), 2);
    chk_all("R9");
  endtask

  task automatic t_rx_ovf();
    for (int i = 0; i < 127; i++) step(0,0,1,0,0);
    chk("R7 rx 255", int'(word[7:0]), 255);
    step(0,0,1,0,0);
    chk("R7 rx wrap", int'(word[7:0]), 0);
    chk("R8 passive at low count", int'(st), 2);
    step(0,0,1,0,0); step(0,0,0,1,0);
    chk("R7 rx frozen", int'(word[7:0]), 0);
    chk_all("R8");
  endtask

  task automatic t_tx_ovf();
    for (int i = 0; i < 31; i++) step(1,0,0,0,0);
    for (int i = 0; i < 6; i++) step(0,1,0,0,0);
    chk("R2 tx 242", int'(word[15:8]), 242);
    step(1,0,0,0,0);
    chk("R5 tx 250", int'(word[15:8]), 250);
    step(1,0,0,0,0);
    chk("R5 tx wrap 2", int'(word[15:8]), 2);
    chk("R6 busoff over passive", int'(st), 3);
    step(1,0,0,0,0); step(0,1,0,0,0); step(0,1,0,0,0);
    chk("R5 tx frozen", int'(word[15:8]), 2);
    chk("R6 busoff sticky", int'(st), 3);
    chk_all("R6");
  endtask

  task automatic t_recover();
    step(1,0,1,0,1);
    chk("R10 word", int'(word), 0);
    chk("R10 state", int'(st), 0);
    step(0,0,1,0,0);
    chk("R10 counting resumes", int'(word[7:0]), 1);
  endtask

  initial begin
    #200000ns;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_rx_basic();
    t_priority();
    t_levels();
    t_rx_ovf();
    t_tx_ovf();
    t_recover();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule